// File: doc/BRIEF.md
# Instruction Immediate Builder

This block turns a 32-bit instruction word into the signed immediate operand that the execute stage needs. A two-bit format code tells it how the immediate bits are spread across the instruction: the register-immediate and load layout, the store layout, or the conditional-branch layout. The block gathers the scattered bits back into order and sign-extends the result to the full data width.

The unit is purely combinational, with no register stage. Every output bit is either a fixed instruction bit, a constant zero, or a two-way choice between two instruction bits. Which format to request is decided by the opcode decoder upstream; this block only assembles the value. Branch offsets come out as byte offsets with the implicit zero in bit 0 already inserted, so they can go straight into the program-counter adder.

Top module: `rv_imm_builder`

## Requirements
- R1: With format code 2'b00 (register-immediate), output bits [11:0] equal instruction bits [31:20].
- R2: With format code 2'b01 (store), output bits [4:0] equal instruction bits [11:7] and output bits [11:5] equal instruction bits [31:25].
- R3: With format code 2'b10 (branch), output bit 0 is always 0, bits [4:1] equal instruction bits [11:8], bits [10:5] equal instruction bits [30:25], bit 11 equals instruction bit 7 and bit 12 equals instruction bit 31.
- R4: For the three valid format codes, every output bit above the top field bit (above bit 11 for codes 00 and 01, above bit 12 for code 10) is a copy of instruction bit 31.
- R5: Branch offsets cover every even value from -4096 to +4094; both extremes come out exactly.
- R6: Register-immediate and store offsets cover -2048 to +2047; both extremes come out exactly.
- R7: Format code 2'b11 drives an all-zero output whatever the instruction.
- R8: Instruction bits outside the selected format's immediate fields have no effect on the output: bits [19:0] for code 00, bits [24:12] and [6:0] for codes 01 and 10.
- R9: The output follows a change of instruction or format code within the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to draw the immediate from |
| fmt_i | input | 2 | Format code: 00 register-immediate, 01 store, 10 branch, 11 none |
| imm_o | output | XLEN (32) | Reassembled, sign-extended immediate |

## Verification
Because the block holds no state, a wrong selection shows up at once as a wrong output bit for the very instruction that exposes it; nothing lingers into later cycles. A swapped mux leg appears as the wrong bit only when the two candidate instruction bits differ, so the stimulus pairs each field with filler that disagrees with it. A faulty sign fill shows only for negative offsets, which is why the extreme values of each format are applied, and an error in the branch bit-11 or bit-0 handling shows for offsets with those bits set.

// File: rtl/imm_pkg.sv
// Package: shared format encoding and instruction field positions for
// the immediate builder. Assumes a 32-bit instruction word.
package imm_pkg;

    localparam int INSTR_W = 32;

    // Format codes as seen on the fmt_i port.
    typedef enum logic [1:0] {
        FMT_REGIMM = 2'b00,
        FMT_STORE  = 2'b01,
        FMT_BRANCH = 2'b10,
        FMT_NONE   = 2'b11
    } imm_fmt_e;

    // Bit positions of immediate pieces inside the instruction.
    localparam int SIGN_POS    = 31;
    localparam int HI_FIELD_LO = 25;   // shared bits [30:25]
    localparam int REGIMM_LO   = 20;   // low five bits, register-immediate
    localparam int STORE_LO    = 7;    // low five bits, store and branch
    localparam int LOW_W       = 5;
    localparam int MID_W       = 6;

endpackage

// File: rtl/imm_fmt_decode.sv
// Module: imm_fmt_decode
// Turns the two-bit format code into the three select lines the slices
// need. Assumes nothing beyond the encoding held in imm_pkg.
module imm_fmt_decode
    import imm_pkg::*;
(
    input  logic [1:0] fmt_i,
    output logic       is_regimm_o,
    output logic       is_branch_o,
    output logic       is_valid_o
);

    imm_fmt_e fmt;

    // Purpose: decode the format code into one flag per needed condition.
    always_comb begin
        fmt         = imm_fmt_e'(fmt_i);
        is_regimm_o = (fmt == FMT_REGIMM);
        is_branch_o = (fmt == FMT_BRANCH);
        is_valid_o  = (fmt != FMT_NONE);
    end

endmodule

// File: rtl/imm_low_slice.sv
// Module: imm_low_slice
// Builds immediate bits [4:0]. Each bit is a two-way choice between the
// register-immediate position and the store position; bit 0 is forced to
// zero for branches. Assumes the caller masks the result for invalid codes.
module imm_low_slice
    import imm_pkg::*;
#(
    parameter int W = LOW_W
) (
    input  logic [W-1:0] regimm_bits_i,
    input  logic [W-1:0] store_bits_i,
    input  logic         is_regimm_i,
    input  logic         is_branch_i,
    output logic [W-1:0] low_o
);

    // Bit 0 carries the implicit zero of branch offsets.
    // Purpose: three-way choice for the least significant bit.
    always_comb begin
        if (is_regimm_i)      low_o[0] = regimm_bits_i[0];
        else if (is_branch_i) low_o[0] = 1'b0;
        else                  low_o[0] = store_bits_i[0];
    end

    // Remaining bits: one two-way mux each.
    for (genvar b = 1; b < W; b++) begin : g_lowmux
        assign low_o[b] = is_regimm_i ? regimm_bits_i[b] : store_bits_i[b];
    end

endmodule

// File: rtl/imm_high_slice.sv
// Module: imm_high_slice
// Builds immediate bits [XLEN-1:5]: the shared six-bit field, bit 11
// (sign copy or branch bit), and the sign fill above. Assumes XLEN >= 13.
module imm_high_slice
    import imm_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int OUT_W = XLEN - LOW_W
) (
    input  logic [MID_W-1:0] mid_bits_i,
    input  logic             sign_i,
    input  logic             br_bit11_i,
    input  logic             is_branch_i,
    output logic [OUT_W-1:0] high_o
);

    localparam int FILL_LO = MID_W + 1;   // index of imm bit 12 in high_o

    // Bits [10:5] sit at the same place in every format.
    assign high_o[MID_W-1:0] = mid_bits_i;

    // Bit 11: branch keeps a separate bit; other formats copy the sign.
    assign high_o[MID_W] = is_branch_i ? br_bit11_i : sign_i;

    // Bits 12 and above: sign fill, one wire per bit.
    for (genvar b = FILL_LO; b < OUT_W; b++) begin : g_fill
        assign high_o[b] = sign_i;
    end

endmodule

// File: rtl/rv_imm_builder.sv
// Module: rv_imm_builder (top)
// Reassembles the sign-extended immediate of a register-immediate, store
// or branch instruction. Purely combinational. Assumes the format code
// comes from an upstream opcode decoder; code 11 yields zero.
module rv_imm_builder
    import imm_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [1:0]         fmt_i,
    output logic [XLEN-1:0]    imm_o
);

    logic            is_regimm;
    logic            is_branch;
    logic            is_valid;
    logic [LOW_W-1:0] low_bits;
    logic [XLEN-LOW_W-1:0] high_bits;
    logic            unused_instr_bits;

    // Instruction bits that never feed any immediate.
    assign unused_instr_bits = ^{instr_i[19:12], instr_i[6:0]};

    imm_fmt_decode u_dec (
        .fmt_i       (fmt_i),
        .is_regimm_o (is_regimm),
        .is_branch_o (is_branch),
        .is_valid_o  (is_valid)
    );

    imm_low_slice #(.W(LOW_W)) u_low (
        .regimm_bits_i (instr_i[REGIMM_LO +: LOW_W]),
        .store_bits_i  (instr_i[STORE_LO +: LOW_W]),
        .is_regimm_i   (is_regimm),
        .is_branch_i   (is_branch),
        .low_o         (low_bits)
    );

    imm_high_slice #(.XLEN(XLEN)) u_high (
        .mid_bits_i  (instr_i[HI_FIELD_LO +: MID_W]),
        .sign_i      (instr_i[SIGN_POS]),
        .br_bit11_i  (instr_i[STORE_LO]),
        .is_branch_i (is_branch),
        .high_o      (high_bits)
    );

    // Purpose: join the slices and clear the result for the unused code.
    always_comb begin
        imm_o = is_valid ? {high_bits, low_bits} : '0;
    end

endmodule

// File: rtl/rv_imm_builder_chk.sv
// Module: rv_imm_builder_chk
// Checker bound to rv_imm_builder. The block is combinational, so the
// checks are immediate assertions evaluated whenever the ports change.
module rv_imm_builder_chk #(
    parameter int XLEN = 32
) (
    input logic [31:0]     instr_i,
    input logic [1:0]      fmt_i,
    input logic [XLEN-1:0] imm_o
);

    // Purpose: compare each output field with its instruction source.
    always_comb begin
        if (fmt_i == 2'b00) begin
            a_r1_regimm_field: assert (imm_o[11:0] == instr_i[31:20])
                else $error("R1 register-immediate field mismatch");
        end
        if (fmt_i == 2'b01) begin
            a_r2_store_field: assert (imm_o[11:0] == {instr_i[31:25], instr_i[11:7]})
                else $error("R2 store field mismatch");
        end
        if (fmt_i == 2'b10) begin
            a_r3_branch_lsb: assert (imm_o[0] == 1'b0)
                else $error("R3 branch bit 0 not zero");
            a_r3_branch_field: assert (imm_o[12:1] == {instr_i[31], instr_i[7],
                                                       instr_i[30:25], instr_i[11:8]})
                else $error("R3 branch field mismatch");
        end
        if (fmt_i != 2'b11) begin
            a_r4_sign_fill: assert (imm_o[XLEN-1:12] == {(XLEN-12){instr_i[31]}})
                else $error("R4 sign fill mismatch");
        end
        if (fmt_i == 2'b11) begin
            a_r7_none_zero: assert (imm_o == '0)
                else $error("R7 unused code not zero");
        end
    end

endmodule

bind rv_imm_builder rv_imm_builder_chk #(.XLEN(XLEN)) u_chk (
    .instr_i (instr_i),
    .fmt_i   (fmt_i),
    .imm_o   (imm_o)
);

// File: tb/rv_imm_builder_tb_top.sv
// Directed bench for rv_imm_builder: one task per scenario.
module rv_imm_builder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN       = 32;

    logic              clk = 1'b0;
    logic [31:0]       instr;
    logic [1:0]        fmt;
    logic [XLEN-1:0]   imm;
    int                n_checks = 0;
    int                n_fail   = 0;
    bit                done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rv_imm_builder #(.XLEN(XLEN)) dut_i (
        .instr_i (instr),
        .fmt_i   (fmt),
        .imm_o   (imm)
    );

    // Encoders build instructions from a signed offset plus filler bits.
    function automatic logic [31:0] enc_regimm(input logic [11:0] off, input logic [19:0] rest);
        return {off, rest};
    endfunction

    function automatic logic [31:0] enc_store(input logic [11:0] off, input logic [12:0] mid,
                                              input logic [6:0] op);
        return {off[11:5], mid, off[4:0], op};
    endfunction

    function automatic logic [31:0] enc_branch(input logic [12:0] off, input logic [12:0] mid,
                                               input logic [6:0] op);
        return {off[12], off[10:5], mid, off[4:1], off[11], op};
    endfunction

    function automatic logic [XLEN-1:0] sx12(input logic [11:0] v);
        return {{(XLEN-12){v[11]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] sx13(input logic [12:0] v);
        return {{(XLEN-13){v[12]}}, v[12:1], 1'b0};
    endfunction

    task automatic check(input string req, input logic [XLEN-1:0] exp);
        n_checks++;
        if (imm !== exp) begin
            n_fail++;
            $display("FAIL %s: imm=%h expected %h (instr=%h fmt=%b)", req, imm, exp, instr, fmt);
        end
    endtask

    // Drive at the falling edge, sample a quarter period later.
    task automatic apply(input logic [31:0] ins, input logic [1:0] f);
        @(negedge clk);
        instr = ins;
        fmt   = f;
        #(CLK_PERIOD/4);
    endtask

    task automatic t_start_state();
        apply(32'hFFFF_FFFF, 2'b11);
        check("R7 start state", '0);
    endtask

    task automatic t_regimm();
        apply(enc_regimm(12'h123, 20'h5A5A5), 2'b00);
        check("R1 positive", sx12(12'h123));
        apply(enc_regimm(12'hFCE, 20'h0F0F0), 2'b00);   // -50
        check("R1 R4 negative", sx12(12'hFCE));
    endtask

    task automatic t_store();
        apply(enc_store(12'h008, 13'h1ABC, 7'h23), 2'b01);
        check("R2 small", sx12(12'h008));
        apply(enc_store(12'hA5F, 13'h0543, 7'h5C), 2'b01);
        check("R2 R4 negative", sx12(12'hA5F));
    endtask

    task automatic t_branch();
        apply(enc_branch(13'h0808, 13'h0F0F, 7'h63), 2'b10);  // bit 11 set
        check("R3 bit11", sx13(13'h0808));
        apply(enc_branch(13'h1F3E, 13'h1234, 7'h7F), 2'b10);
        check("R3 R4 negative", sx13(13'h1F3E));
        // Odd offset bit 0 cannot be encoded; bit 7 drives imm[11] only.
        apply(32'h0000_0080, 2'b10);
        check("R3 lsb zero", 32'h0000_0800);
    endtask

    task automatic t_extremes();
        apply(enc_branch(13'h1000, 13'h0000, 7'h63), 2'b10);
        check("R5 min -4096", 32'hFFFF_F000);
        apply(enc_branch(13'h0FFE, 13'h1FFF, 7'h63), 2'b10);
        check("R5 max 4094", 32'h0000_0FFE);
        apply(enc_regimm(12'h800, 20'hFFFFF), 2'b00);
        check("R6 regimm min", 32'hFFFF_F800);
        apply(enc_regimm(12'h7FF, 20'h00000), 2'b00);
        check("R6 regimm max", 32'h0000_07FF);
        apply(enc_store(12'h800, 13'h1FFF, 7'h7F), 2'b01);
        check("R6 store min", 32'hFFFF_F800);
        apply(enc_store(12'h7FF, 13'h0000, 7'h00), 2'b01);
        check("R6 store max", 32'h0000_07FF);
    endtask

    task automatic t_ignored();
        for (int k = 0; k < 4; k++) begin
            logic [19:0] rest = 20'h13579 * (k + 1);
            logic [12:0] mid  = 13'h0ACE ^ (13'h0111 * k);
            apply(enc_regimm(12'h9C4, rest), 2'b00);
            check("R8 regimm filler", sx12(12'h9C4));
            apply(enc_store(12'h3B1, mid, 7'(k * 37)), 2'b01);
            check("R8 store filler", sx12(12'h3B1));
            apply(enc_branch(13'h15AA, mid, 7'(k * 53)), 2'b10);
            check("R8 branch filler", sx13(13'h15AA));
        end
    endtask

    task automatic t_none();
        apply(enc_branch(13'h1FFE, 13'h1FFF, 7'h7F), 2'b11);
        check("R7 all-ones instr", '0);
        apply(32'h8000_0000, 2'b11);
        check("R7 sign only", '0);
    endtask

    // Same instruction under each code, then a new instruction mid-cycle.
    task automatic t_comb();
        logic [31:0] ins = enc_store(12'hC35, 13'h0000, 7'h23);
        apply(ins, 2'b00);
        check("R9 as regimm", sx12(ins[31:20]));
        #1 fmt = 2'b01;
        #1 check("R9 same-cycle code change", sx12(12'hC35));
        #1 instr = enc_store(12'h0F0, 13'h0000, 7'h23);
        #1 check("R9 same-cycle instr change", sx12(12'h0F0));
    endtask

    initial begin
        instr = '0;
        fmt   = 2'b11;
        t_start_state();
        t_regimm();
        t_store();
        t_branch();
        t_extremes();
        t_ignored();
        t_none();
        t_comb();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule